// File: doc/BRIEF.md
# Push-Pull Two-Wire Bus Master

This block is a register-mapped controller for a two-wire serial link that has exactly one slave and drives both wires actively. Software fills in a target register address, a data byte and a direction, then sets the start bit. The controller sends the frame on its clock and data outputs. For a write, the frame carries the data byte. For a read, the controller releases the data wire and the slave returns the byte within the same frame. No device address and no acknowledge slots are sent. Each byte is followed by an odd parity bit.

When the frame ends, the controller raises a completion flag. A read whose returned parity does not match also raises an error flag with a code. A start request made while a frame is running raises a separate flag. A maskable interrupt output combines these flags. Software can cut a frame short with an abort bit, or return every register to its reset value with a soft-reset bit.

Top module: `ppbus_master`

## Requirements
- R1: After reset, every register reads 0, `scl_o`, `sda_o` and `sda_oe` are 1, and `irq` is 0.
- R2: Writing control (0x00) with bit 7 set, and bits 6 and 0 clear, while idle starts a frame. Control bit 7 reads 1 while the frame runs and 0 once it ends.
- R3: A frame is laid out as follows. It opens with a start condition: SDA falls while SCL is high. Nineteen bits follow, MSB first, each sampled at an SCL rising edge. These are the direction bit (length register 0x18 bit 4: 1 = read), the 8-bit address from 0x10, a parity bit, 8 data bits and a parity bit. It closes with a stop condition: SDA rises while SCL is high. There is no acknowledge slot. Exactly one byte is moved whatever length bits 2:0 hold.
- R4: Every parity bit makes the count of ones across its byte plus itself odd.
- R5: When a frame finishes, status (0x0C) bit 0 sets. After a read, data (0x1C) bits 7:0 hold the returned byte.
- R6: On a read, the controller sets `sda_oe` to 0 for the 8 data bits and their parity bit, and takes `sda_i` at each SCL rising edge.
- R7: If the returned parity of a read is wrong, status bit 1 sets and status bits 15:8 read 0x01, together with bit 0.
- R8: A start request made while a frame is running sets status bit 2 and leaves the running frame unchanged.
- R9: Writing 1 to any of status bits 2:0 clears that bit only. Writing 0 leaves it as it is.
- R10: `irq` is high when control bit 1 is set and a status bit 2:0 is set whose enable bit at the same position in 0x08 is also set.
- R11: Writing control bit 6 stops a running frame at once. Both lines return high, bit 7 clears, and no completion is flagged.
- R12: Writing control bit 0 returns every register, and the engine, to the reset state.
- R13: Clock control (0x04) sets the timing. Bits 7:0 give DIV, with 0 treated as 1, and bits 10:8 give DLY. SCL stays high for DIV cycles and low for DIV cycles. A driven SDA bit changes min(DLY, DIV-1) cycles after SCL falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (same cycle) |
| irq | output | 1 | Interrupt request |
| scl_o | output | 1 | Serial clock line |
| sda_o | output | 1 | Serial data output |
| sda_oe | output | 1 | Data output enable (0 = slave drives) |
| sda_i | input | 1 | Serial data input |

## Verification
The hardest case to reach is the read with bad parity. The bench has to act as the slave and drive `sda_i` in step with the controller's own SCL, and it must place the wrong bit exactly in the ninth returned slot. The bench model watches SCL fall, counts the rising edges seen since the start condition, and presents the next bit of a stored reply vector. Flipping the last bit of that vector produces the error. The data-line delay clamp is reached by setting DLY above DIV-1 on a frame whose address alternates 0 and 1, so that SDA changes and its timing can be measured.

// File: rtl/ppbus_pkg.sv
// Shared constants for the push-pull two-wire master.
// Assumes byte-addressed registers on a word-wide register bus.
package ppbus_pkg;
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_CLK  = 'h04;
    localparam int OFS_IEN  = 'h08;
    localparam int OFS_STS  = 'h0C;
    localparam int OFS_REG  = 'h10;
    localparam int OFS_LEN  = 'h18;
    localparam int OFS_DATA = 'h1C;

    localparam int CB_START = 7;
    localparam int CB_ABORT = 6;
    localparam int CB_GIE   = 1;
    localparam int CB_SRST  = 0;

    localparam logic [7:0] ERR_PARITY = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_STOPL, ST_STOPH
    } eng_state_t;
endpackage

// File: rtl/ppbus_bitclk.sv
// Half-period timer for the serial clock. It counts input cycles while
// run is high and pulses half_done at the last cycle of each half.
// Assumes a divider of 0 means 1.
module ppbus_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_done,
    output logic [DIV_W-1:0] cnt,
    output logic [DIV_W-1:0] last_cnt
);
    assign last_cnt  = (div == '0) ? '0 : div - 1'b1;
    assign half_done = run && (cnt == last_cnt);

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (half_done) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ppbus_engine.sv
// Frame sequencer: start, direction, address+parity, data+parity, stop.
// Assumes the half-period timer restarts when busy rises.
module ppbus_engine #(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              rw,
    input  logic [BYTE_W-1:0] tgt_reg,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [DLY_W-1:0]  dly,
    input  logic              half_done,
    input  logic [DIV_W-1:0]  cnt,
    input  logic [DIV_W-1:0]  last_cnt,
    input  logic              sda_i,
    output logic              busy,
    output logic              done,
    output logic              perr,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_o,
    output logic              sda_o,
    output logic              sda_oe
);
    import ppbus_pkg::*;

    localparam int FRAME_W = 2 * BYTE_W + 3;
    localparam int IW      = $clog2(FRAME_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_W - 1);
    localparam logic [IW-1:0] RD_IDX   = IW'(BYTE_W + 1);

    eng_state_t         state;
    logic [FRAME_W-1:0] frame;
    logic [BYTE_W:0]    rx;
    logic [IW-1:0]      idx;
    logic               rd;
    logic [DIV_W-1:0]   dly_ext, dly_eff;
    logic               next_oe;

    assign dly_ext = DIV_W'(dly);
    assign dly_eff = (dly_ext > last_cnt) ? last_cnt : dly_ext;
    assign next_oe = !(rd && idx >= RD_IDX);
    assign busy    = (state != ST_IDLE);
    assign rx_byte = rx[BYTE_W:1];

    // Step the frame one half period at a time and place data bits.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= ST_IDLE; scl_o <= 1'b1; sda_o <= 1'b1; sda_oe <= 1'b1;
            idx <= '0; frame <= '0; rx <= '0; rd <= 1'b0;
            done <= 1'b0; perr <= 1'b0;
        end else begin
            done <= 1'b0;
            perr <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    frame <= {rw, tgt_reg, ~^tgt_reg, tx_byte, ~^tx_byte};
                    rd    <= rw;
                    idx   <= '0;
                    sda_o <= 1'b0;
                    state <= ST_START;
                end
                ST_START: if (half_done) begin
                    scl_o <= 1'b0;
                    state <= ST_LOW;
                    if (dly_eff == '0) begin
                        sda_o <= frame[FRAME_W-1];
                        frame <= frame << 1;
                    end
                end
                ST_LOW: begin
                    if (sda_oe && dly_eff != '0 && cnt == dly_eff - 1'b1) begin
                        sda_o <= frame[FRAME_W-1];
                        frame <= frame << 1;
                    end
                    if (half_done) begin
                        scl_o <= 1'b1;
                        state <= ST_HIGH;
                        if (!sda_oe) rx <= {rx[BYTE_W-1:0], sda_i};
                    end
                end
                ST_HIGH: if (half_done) begin
                    scl_o <= 1'b0;
                    if (idx == LAST_IDX) begin
                        sda_o  <= 1'b0;
                        sda_oe <= 1'b1;
                        state  <= ST_STOPL;
                    end else begin
                        idx    <= idx + 1'b1;
                        sda_oe <= next_oe;
                        state  <= ST_LOW;
                        if (next_oe && dly_eff == '0) begin
                            sda_o <= frame[FRAME_W-1];
                            frame <= frame << 1;
                        end
                    end
                end
                ST_STOPL: if (half_done) begin
                    scl_o <= 1'b1;
                    state <= ST_STOPH;
                end
                ST_STOPH: if (half_done) begin
                    sda_o <= 1'b1;
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    perr  <= rd && (rx[0] != ~^rx[BYTE_W:1]);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ppbus_regs.sv
// Register file: control, clock control, interrupt enable, status with
// write-1-to-clear, target address, length and data. Reads are
// combinational. Assumes BUS_DW >= 16.
module ppbus_regs #(
    parameter int BUS_AW = 8,
    parameter int BUS_DW = 32,
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              perr,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              start_req,
    output logic              abort_req,
    output logic              soft_rst,
    output logic              irq,
    output logic              xfer_rd,
    output logic [BYTE_W-1:0] tgt_reg,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [DIV_W-1:0]  div,
    output logic [DLY_W-1:0]  dly
);
    import ppbus_pkg::*;

    localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
    localparam logic [BUS_AW-1:0] A_CLK  = BUS_AW'(OFS_CLK);
    localparam logic [BUS_AW-1:0] A_IEN  = BUS_AW'(OFS_IEN);
    localparam logic [BUS_AW-1:0] A_STS  = BUS_AW'(OFS_STS);
    localparam logic [BUS_AW-1:0] A_REG  = BUS_AW'(OFS_REG);
    localparam logic [BUS_AW-1:0] A_LEN  = BUS_AW'(OFS_LEN);
    localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(OFS_DATA);

    logic       gie;
    logic [2:0] ien, sts, sts_clr, sts_set;
    logic [7:0] err_id;
    logic [2:0] len_cnt;
    logic       wr, ctrl_wr, go_bit, load_bsy;
    logic       unused_wdata;

    assign wr        = bus_sel && bus_wr;
    assign ctrl_wr   = wr && bus_addr == A_CTRL;
    assign soft_rst  = ctrl_wr && bus_wdata[CB_SRST];
    assign abort_req = ctrl_wr && bus_wdata[CB_ABORT] && !bus_wdata[CB_SRST];
    assign go_bit    = ctrl_wr && bus_wdata[CB_START] && !bus_wdata[CB_ABORT]
                       && !bus_wdata[CB_SRST];
    assign start_req = go_bit && !busy;
    assign load_bsy  = go_bit && busy;
    assign sts_clr   = (wr && bus_addr == A_STS) ? bus_wdata[2:0] : 3'b000;
    assign sts_set   = {load_bsy, perr, done};
    assign irq       = gie && |(sts & ien);
    assign unused_wdata = ^bus_wdata;

    // Hold software-visible state and collect engine events.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            gie <= 1'b0; ien <= '0; sts <= '0; err_id <= '0;
            div <= '0; dly <= '0; tgt_reg <= '0; tx_byte <= '0;
            xfer_rd <= 1'b0; len_cnt <= '0;
        end else begin
            if (ctrl_wr) gie <= bus_wdata[CB_GIE];
            if (wr && bus_addr == A_CLK) begin
                div <= bus_wdata[DIV_W-1:0];
                dly <= bus_wdata[8 +: DLY_W];
            end
            if (wr && bus_addr == A_IEN) ien <= bus_wdata[2:0];
            if (wr && bus_addr == A_REG) tgt_reg <= bus_wdata[BYTE_W-1:0];
            if (wr && bus_addr == A_LEN) begin
                xfer_rd <= bus_wdata[4];
                len_cnt <= bus_wdata[2:0];
            end
            if (wr && bus_addr == A_DATA) tx_byte <= bus_wdata[BYTE_W-1:0];
            if (done && xfer_rd) tx_byte <= rx_byte;
            sts <= (sts & ~sts_clr) | sts_set;
            if (perr)            err_id <= ERR_PARITY;
            else if (sts_clr[1]) err_id <= '0;
        end
    end

    // Return the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CB_START] = busy;
                bus_rdata[CB_GIE]   = gie;
            end
            A_CLK: begin
                bus_rdata[DIV_W-1:0] = div;
                bus_rdata[8 +: DLY_W] = dly;
            end
            A_IEN:  bus_rdata[2:0] = ien;
            A_STS: begin
                bus_rdata[2:0]  = sts;
                bus_rdata[15:8] = err_id;
            end
            A_REG:  bus_rdata[BYTE_W-1:0] = tgt_reg;
            A_LEN: begin
                bus_rdata[4]   = xfer_rd;
                bus_rdata[2:0] = len_cnt;
            end
            A_DATA: bus_rdata[BYTE_W-1:0] = tx_byte;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppbus_master.sv
// Top of the push-pull two-wire master: register file, half-period
// timer and frame sequencer. Assumes a single slave on the link.
module ppbus_master #(
    parameter int BUS_AW = 8,
    parameter int BUS_DW = 32,
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq,
    output logic              scl_o,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic              sda_i
);
    logic              eng_busy, eng_done, eng_perr, eng_abort;
    logic              start_req, abort_req, soft_rst, xfer_rd;
    logic              half_done;
    logic [BYTE_W-1:0] rx_byte, tgt_reg, tx_byte;
    logic [DIV_W-1:0]  div, cnt, last_cnt;
    logic [DLY_W-1:0]  dly;

    assign eng_abort = abort_req || soft_rst;

    ppbus_regs #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .BYTE_W(BYTE_W),
                 .DIV_W(DIV_W), .DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(eng_busy), .done(eng_done), .perr(eng_perr), .rx_byte(rx_byte),
        .start_req(start_req), .abort_req(abort_req), .soft_rst(soft_rst),
        .irq(irq), .xfer_rd(xfer_rd), .tgt_reg(tgt_reg), .tx_byte(tx_byte),
        .div(div), .dly(dly)
    );

    ppbus_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div),
        .half_done(half_done), .cnt(cnt), .last_cnt(last_cnt)
    );

    ppbus_engine #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start_req), .abort(eng_abort),
        .rw(xfer_rd), .tgt_reg(tgt_reg), .tx_byte(tx_byte), .dly(dly),
        .half_done(half_done), .cnt(cnt), .last_cnt(last_cnt), .sda_i(sda_i),
        .busy(eng_busy), .done(eng_done), .perr(eng_perr), .rx_byte(rx_byte),
        .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/ppbus_master_chk.sv
// Protocol checker for ppbus_master, attached by bind below.
module ppbus_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic abort,
    input logic half_done,
    input logic scl_o,
    input logic sda_o,
    input logic sda_oe,
    input logic irq,
    input logic bus_sel,
    input logic bus_wr
);
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o && sda_oe));

    assert_release_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe |-> busy);

    assert_done_ends_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_abort_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    assert_scl_on_half_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_o) |-> ($past(half_done) || $past(abort)));

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(done) || $past(bus_sel && bus_wr)));
endmodule

bind ppbus_master ppbus_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .done(eng_done),
    .abort(eng_abort), .half_done(half_done), .scl_o(scl_o), .sda_o(sda_o),
    .sda_oe(sda_oe), .irq(irq), .bus_sel(bus_sel), .bus_wr(bus_wr)
);

// File: tb/ppbus_master_test.sv
module ppbus_master_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq, scl_o, sda_o, sda_oe;
    logic        sda_i = 1'b1;

    int checks = 0, failures = 0;

    // slave model and line monitor state
    logic [8:0]  reply = '0;
    logic [31:0] mon_vec = '0, oe_vec = '0, got_vec = '0, got_oe = '0;
    int mon_cnt = 0, got_n = 0, frames = 0;
    int hcnt = 0, lcnt = 0, fcnt = 0, high_len = 0, low_len = 0, dly_meas = -1;
    logic in_frame = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;

    ppbus_master uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor the lines and play the slave, away from the active edge.
    always @(negedge clk) begin
        if (scl_o && prev_scl && prev_sda && !sda_o && sda_oe && !in_frame) begin
            in_frame = 1'b1; mon_cnt = 0; mon_vec = '0; oe_vec = '0;
        end else if (scl_o && prev_scl && !prev_sda && sda_o && sda_oe && in_frame) begin
            in_frame = 1'b0; got_vec = mon_vec >> 1; got_oe = oe_vec >> 1;
            got_n = mon_cnt - 1; frames++;
        end
        if (scl_o && !prev_scl) begin
            low_len = lcnt; hcnt = 1;
            if (in_frame) begin
                mon_vec = {mon_vec[30:0], sda_oe ? sda_o : sda_i};
                oe_vec  = {oe_vec[30:0], sda_oe};
                mon_cnt++;
            end
        end else if (scl_o) hcnt++;
        if (!scl_o) begin
            if (prev_scl) begin high_len = hcnt; lcnt = 1; fcnt = 0; end
            else begin lcnt++; fcnt++; end
            if (in_frame && sda_oe && sda_o != prev_sda && mon_cnt < 19) dly_meas = fcnt;
            sda_i = (in_frame && mon_cnt >= 10 && mon_cnt <= 18) ? reply[18 - mon_cnt] : 1'b1;
        end
        prev_scl = scl_o;
        prev_sda = sda_o;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(8'h0C, s);
            if (s[0]) break;
        end
    endtask

    task automatic launch(input logic rd, input logic [7:0] a, input logic [7:0] d,
                          input logic [7:0] dv, input logic [2:0] dl);
        bus_write(8'h04, {21'd0, dl, dv});
        bus_write(8'h10, {24'd0, a});
        bus_write(8'h1C, {24'd0, d});
        bus_write(8'h18, {27'd0, rd, 4'd0});
        bus_write(8'h00, 32'h80);
    endtask

    function automatic logic [18:0] wframe(input logic rd, input logic [7:0] a,
                                            input logic [8:0] tail);
        return {rd, a, ~^a, tail};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 7; k++) begin
            bus_read(8'(k == 5 ? 'h18 : (k == 6 ? 'h1C : k * 4)), v);
            chk("R1", "register after reset", v, 32'h0);
        end
        chk("R1", "lines after reset", {29'd0, scl_o, sda_o, sda_oe}, 32'h7);
        chk("R1", "irq after reset", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        launch(1'b0, 8'hA5, 8'h3C, 8'd3, 3'd1);
        bus_read(8'h00, v);
        chk("R2", "busy flag during frame", {31'd0, v[7]}, 32'h1);
        wait_done();
        repeat (4) @(negedge clk);
        chk("R3", "write frame bit count", 32'(got_n), 32'd19);
        chk("R3", "write frame bits", got_vec, {13'd0, wframe(1'b0, 8'hA5, {8'h3C, ~^8'h3C})});
        chk("R4", "address parity bit", {31'd0, got_vec[9]}, {31'd0, ~^8'hA5});
        bus_read(8'h0C, v);
        chk("R5", "status after write", v, 32'h1);
        bus_read(8'h00, v);
        chk("R2", "busy flag after frame", {31'd0, v[7]}, 32'h0);
        bus_write(8'h0C, 32'h7);
    endtask

    task automatic t_read(input logic bad);
        logic [31:0] v;
        reply = {8'h96, (~^8'h96) ^ bad};
        launch(1'b1, 8'h3E, 8'h00, 8'd2, 3'd0);
        wait_done();
        repeat (4) @(negedge clk);
        chk("R3", "read frame bits", got_vec, {13'd0, wframe(1'b1, 8'h3E, reply)});
        chk("R6", "oe released for reply only", got_oe, {13'd0, 10'h3FF, 9'h0});
        bus_read(8'h1C, v);
        chk("R5", "read data register", v, 32'h96);
        bus_read(8'h0C, v);
        if (bad) chk("R7", "status after parity error", v, 32'h0103);
        else     chk("R6", "status after good read", v, 32'h1);
        bus_write(8'h0C, 32'h7);
        bus_read(8'h0C, v);
        chk("R9", "status cleared", v, 32'h0);
    endtask

    task automatic t_busy_load();
        logic [31:0] v;
        int f0 = frames;
        launch(1'b0, 8'h5A, 8'hC3, 8'd3, 3'd1);
        bus_write(8'h00, 32'h80);
        wait_done();
        repeat (4) @(negedge clk);
        bus_read(8'h0C, v);
        chk("R8", "status after start while busy", v, 32'h5);
        chk("R8", "frame unchanged", got_vec, {13'd0, wframe(1'b0, 8'h5A, {8'hC3, ~^8'hC3})});
        repeat (200) @(negedge clk);
        chk("R8", "single frame sent", 32'(frames - f0), 32'd1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        bus_write(8'h0C, 32'h1);
        bus_read(8'h0C, v);
        chk("R9", "clear bit0 only", v, 32'h4);
        bus_write(8'h0C, 32'h0);
        bus_read(8'h0C, v);
        chk("R9", "zero write keeps bits", v, 32'h4);
        bus_write(8'h0C, 32'h4);
        bus_read(8'h0C, v);
        chk("R9", "clear bit2", v, 32'h0);
    endtask

    task automatic t_irq();
        launch(1'b0, 8'h11, 8'h22, 8'd1, 3'd0);
        wait_done();
        bus_write(8'h08, 32'h1);
        @(negedge clk);
        chk("R10", "irq without global enable", {31'd0, irq}, 32'h0);
        bus_write(8'h00, 32'h2);
        @(negedge clk);
        chk("R10", "irq enabled and pending", {31'd0, irq}, 32'h1);
        bus_write(8'h08, 32'h6);
        @(negedge clk);
        chk("R10", "irq masked", {31'd0, irq}, 32'h0);
        bus_write(8'h0C, 32'h7);
        bus_write(8'h08, 32'h0);
        bus_write(8'h00, 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        launch(1'b0, 8'hF0, 8'h0F, 8'd20, 3'd1);
        repeat (100) @(negedge clk);
        bus_write(8'h00, 32'h40);
        bus_read(8'h00, v);
        chk("R11", "busy after abort", {31'd0, v[7]}, 32'h0);
        chk("R11", "lines after abort", {30'd0, scl_o, sda_o}, 32'h3);
        repeat (1000) @(negedge clk);
        bus_read(8'h0C, v);
        chk("R11", "no completion after abort", v, 32'h0);
    endtask

    task automatic t_timing(input logic [7:0] dv, input logic [2:0] dl, input int exp_dly);
        launch(1'b0, 8'h55, 8'hAA, dv, dl);
        wait_done();
        repeat (4) @(negedge clk);
        chk("R13", "scl high cycles", 32'(high_len), 32'(dv));
        chk("R13", "scl low cycles", 32'(low_len), 32'(dv));
        chk("R13", "sda delay after fall", 32'(dly_meas), 32'(exp_dly));
        bus_write(8'h0C, 32'h7);
    endtask

    task automatic t_softrst();
        logic [31:0] v;
        bus_write(8'h04, 32'h105);
        bus_write(8'h08, 32'h7);
        bus_write(8'h10, 32'h77);
        bus_write(8'h18, 32'h13);
        bus_write(8'h1C, 32'h12);
        bus_write(8'h00, 32'h3);
        for (int k = 0; k < 7; k++) begin
            bus_read(8'(k == 5 ? 'h18 : (k == 6 ? 'h1C : k * 4)), v);
            chk("R12", "register after soft reset", v, 32'h0);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read(1'b0);
        t_read(1'b1);
        t_busy_load();
        t_w1c();
        t_irq();
        t_abort();
        t_timing(8'd5, 3'd2, 2);
        t_timing(8'd2, 3'd7, 1);
        t_timing(8'd3, 3'd0, 0);
        t_softrst();
        finish_run();
    end
endmodule